// File: doc/BRIEF.md
# Zero-Overhead Loop Instruction Cache

This block sits beside a DSP sequencer's fetch path and takes over instruction supply for short loops. When the sequencer signals a loop start with an iteration count and a body length, the block lets the next body words pass through to the decoder while it keeps a copy of each word and its 16/32-bit width tag. The word fetched right after the body is the instruction that follows the loop. The block holds it in a save register and starts issuing the stored body again in that same cycle. All later passes come from the buffer at one instruction per cycle with no gap between passes. During these passes the block reports that the program fetch bus is free, so it can carry coefficient fetches. After the final pass it issues the held follow-on instruction and goes back to pass-through.

For interrupt handling, the sequencer raises `suspend_i` at an instruction boundary. This freezes the block. A handler can then read and write every stored word, the width tags, the remaining pass count, the state word and the follow-on opcode through a small address port. If the handler writes the same values back and then releases `suspend_i`, replay continues at the iteration and offset where it stopped.

Top module: `loop_cache`

## Requirements
- R1: While no loop is active and `suspend_i` is low, `issue_valid_o`, `issue_word_o` and `issue_wide_o` follow `fetch_valid_i`, `fetch_word_i` and `fetch_wide_i` in the same cycle. `fetch_free_o` stays low.
- R2: A loop start with a count of 0, a body length of 0 or a body length above 31 is discarded. The block stays idle and later words pass straight through.
- R3: After an accepted loop start, the next body-length valid fetched words are issued unchanged and stored in order as entries 0 upward.
- R4: The valid fetched word that follows the body is taken as the follow-on opcode and is not issued. If the count is above 1, stored entry 0 is issued in that same cycle. Stored entries then issue one per cycle, with no gap, until the body has run the programmed number of times in total (up to 65535). `fetch_free_o` is high on every cycle that issues from storage, except the cycle that captures the follow-on word.
- R5: In the cycle after the last replayed entry, the follow-on opcode is issued with its own width tag. In the cycle after that, the block is idle and passes words through.
- R6: With a count of 1, the follow-on word is issued directly in the cycle it is fetched, and the block is idle in the next cycle.
- R7: Every replayed instruction carries the width tag it had when it was stored (1 = 32-bit, 0 = 16-bit).
- R8: While `suspend_i` is high, nothing is issued, `fetch_free_o` is low and the loop state does not advance.
- R9: The register port reads combinationally and writes on the clock edge. Addresses 0..30 are the stored words. Address 32 is the remaining replay passes. Address 33 is the state word: bits [1:0] hold the mode (0 idle, 1 filling, 2 replaying, 3 issuing the follow-on), bits [6:2] the next entry offset and bits [11:7] the body length. Address 34 is the follow-on opcode. Address 35 holds the entry width tags in bits [30:0] and the follow-on width tag in bit 31.
- R10: Writing back saved port values while suspended and then releasing `suspend_i` resumes replay at the same pass and offset, and the remaining instruction stream is the same as if no interrupt had occurred.
- R11: While replaying or issuing the follow-on, fetched words and loop-start commands have no effect on the issued stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_valid_i | input | 1 | Fetched instruction word valid |
| fetch_word_i | input | 32 | Fetched instruction word |
| fetch_wide_i | input | 1 | Fetched word is a 32-bit instruction |
| loop_start_i | input | 1 | Loop command seen in the current cycle |
| loop_cnt_i | input | 16 | Total number of body executions |
| loop_len_i | input | 6 | Body length in instructions |
| suspend_i | input | 1 | Freeze at instruction boundary for interrupt |
| reg_we_i | input | 1 | Register port write strobe |
| reg_addr_i | input | 6 | Register port address |
| reg_wdata_i | input | 32 | Register port write data |
| reg_rdata_o | output | 32 | Register port read data |
| issue_valid_o | output | 1 | Instruction issued to the decoder |
| issue_word_o | output | 32 | Issued instruction word |
| issue_wide_o | output | 1 | Issued word is a 32-bit instruction |
| fetch_free_o | output | 1 | Program fetch bus not needed this cycle |
| loop_active_o | output | 1 | A loop is being filled or replayed |

## Verification
The replay path is exercised with four patterns. A three-word body run three times, with mixed width tags, shows the order of fill, replay and exit, and shows width retention. A one-pass loop shows the direct follow-on bypass, as opposed to a replay. A one-word body run 65535 times checks both the count limit and a gap-free stream. A two-word body is suspended between passes, clobbered, restored and resumed, which separates true state restoration from a restart. Fetch words and loop commands are injected during replay to show they are ignored, and three malformed loop starts show they never enter fill.

// File: rtl/lc_pkg.sv
package lc_pkg;
  typedef enum logic [1:0] {
    M_IDLE   = 2'd0,
    M_FILL   = 2'd1,
    M_REPLAY = 2'd2,
    M_EXIT   = 2'd3
  } lc_mode_e;
endpackage

// File: rtl/lc_store.sv
module lc_store #(
  parameter int unsigned DEPTH  = 31,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned PTR_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_we_i,
  input  logic [PTR_W-1:0]  fill_idx_i,
  input  logic [WORD_W-1:0] fill_word_i,
  input  logic              fill_wide_i,
  input  logic              port_we_i,
  input  logic [PTR_W-1:0]  port_idx_i,
  input  logic [WORD_W-1:0] port_word_i,
  input  logic              mask_we_i,
  input  logic [DEPTH-1:0]  mask_i,
  input  logic [PTR_W-1:0]  rd_idx_i,
  output logic [WORD_W-1:0] rd_word_o,
  output logic              rd_wide_o,
  output logic [WORD_W-1:0] port_word_o,
  output logic [DEPTH-1:0]  mask_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WORD_W-1:0] words [DEPTH];
  logic [DEPTH-1:0]  wide_vec;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [WORD_W-1:0] w_q;
    logic              t_q;
    logic              fill_hit, port_hit;
    assign fill_hit = fill_we_i && (fill_idx_i == PTR_W'(i));
    assign port_hit = port_we_i && (port_idx_i == PTR_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        w_q <= '0;
        t_q <= 1'b0;
      end else begin
        // port access wins over fill on a collision
        if (port_hit)      w_q <= port_word_i;
        else if (fill_hit) w_q <= fill_word_i;
        if (mask_we_i)     t_q <= mask_i[i];
        else if (fill_hit) t_q <= fill_wide_i;
      end
    end
    assign words[i]    = w_q;
    assign wide_vec[i] = t_q;
  end

  assign rd_word_o   = (rd_idx_i <= LAST) ? words[rd_idx_i] : '0;
  assign rd_wide_o   = (rd_idx_i <= LAST) ? wide_vec[rd_idx_i] : 1'b0;
  assign port_word_o = (port_idx_i <= LAST) ? words[port_idx_i] : '0;
  assign mask_o      = wide_vec;
endmodule

// File: rtl/lc_seq.sv
module lc_seq
  import lc_pkg::*;
#(
  parameter int unsigned DEPTH  = 31,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PTR_W  = 5,
  parameter int unsigned LEN_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              suspend_i,
  input  logic              loop_start_i,
  input  logic [CNT_W-1:0]  loop_cnt_i,
  input  logic [LEN_W-1:0]  loop_len_i,
  input  logic              fetch_valid_i,
  input  logic [WORD_W-1:0] fetch_word_i,
  input  logic              fetch_wide_i,
  input  logic [WORD_W-1:0] buf_word_i,
  input  logic              buf_wide_i,
  output logic [PTR_W-1:0]  buf_idx_o,
  output logic              fill_we_o,
  output logic [PTR_W-1:0]  fill_idx_o,
  input  logic              cnt_we_i,
  input  logic [CNT_W-1:0]  cnt_wdata_i,
  input  logic              state_we_i,
  input  logic [1:0]        st_mode_i,
  input  logic [PTR_W-1:0]  st_ptr_i,
  input  logic [PTR_W-1:0]  st_len_i,
  input  logic              save_we_i,
  input  logic [WORD_W-1:0] save_wdata_i,
  input  logic              save_wide_we_i,
  input  logic              save_wide_wdata_i,
  output logic              issue_valid_o,
  output logic [WORD_W-1:0] issue_word_o,
  output logic              issue_wide_o,
  output logic              fetch_free_o,
  output lc_mode_e          mode_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [PTR_W-1:0]  len_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [WORD_W-1:0] save_o,
  output logic              save_wide_o
);
  lc_mode_e          mode_q, mode_d, adv_mode;
  logic [PTR_W-1:0]  ptr_q, ptr_d, len_q, len_d, adv_idx, adv_ptr;
  logic [CNT_W-1:0]  cnt_q, cnt_d, adv_cnt;
  logic [WORD_W-1:0] save_q, save_d;
  logic              save_wide_q, save_wide_d;
  logic              start_ok, adv_last;

  assign start_ok = loop_start_i && (loop_cnt_i != '0) && (loop_len_i != '0)
                    && (loop_len_i <= LEN_W'(DEPTH));

  // the capture cycle replays entry 0
  assign adv_idx  = (mode_q == M_FILL) ? '0 : ptr_q;
  assign adv_last = (adv_idx == len_q - 1'b1);

  always_comb begin
    if (adv_last) begin
      adv_ptr  = '0;
      adv_cnt  = cnt_q - 1'b1;
      adv_mode = (cnt_q == CNT_W'(1)) ? M_EXIT : M_REPLAY;
    end else begin
      adv_ptr  = adv_idx + 1'b1;
      adv_cnt  = cnt_q;
      adv_mode = M_REPLAY;
    end
  end

  always_comb begin
    mode_d        = mode_q;
    ptr_d         = ptr_q;
    len_d         = len_q;
    cnt_d         = cnt_q;
    save_d        = save_q;
    save_wide_d   = save_wide_q;
    issue_valid_o = 1'b0;
    issue_word_o  = fetch_word_i;
    issue_wide_o  = fetch_wide_i;
    fill_we_o     = 1'b0;
    if (!suspend_i) begin
      unique case (mode_q)
        M_IDLE: begin
          issue_valid_o = fetch_valid_i;
          if (start_ok) begin
            mode_d = M_FILL;
            ptr_d  = '0;
            len_d  = loop_len_i[PTR_W-1:0];
            cnt_d  = loop_cnt_i - 1'b1;
          end
        end
        M_FILL: begin
          if (fetch_valid_i) begin
            issue_valid_o = 1'b1;
            if (ptr_q != len_q) begin
              fill_we_o = 1'b1;
              ptr_d     = ptr_q + 1'b1;
            end else begin
              save_d      = fetch_word_i;
              save_wide_d = fetch_wide_i;
              if (cnt_q == '0) begin
                mode_d = M_IDLE;
              end else begin
                issue_word_o = buf_word_i;
                issue_wide_o = buf_wide_i;
                mode_d       = adv_mode;
                ptr_d        = adv_ptr;
                cnt_d        = adv_cnt;
              end
            end
          end
        end
        M_REPLAY: begin
          issue_valid_o = 1'b1;
          issue_word_o  = buf_word_i;
          issue_wide_o  = buf_wide_i;
          mode_d        = adv_mode;
          ptr_d         = adv_ptr;
          cnt_d         = adv_cnt;
        end
        M_EXIT: begin
          issue_valid_o = 1'b1;
          issue_word_o  = save_q;
          issue_wide_o  = save_wide_q;
          mode_d        = M_IDLE;
        end
        default: mode_d = M_IDLE;
      endcase
    end
    if (cnt_we_i) cnt_d = cnt_wdata_i;
    if (state_we_i) begin
      mode_d = lc_mode_e'(st_mode_i);
      ptr_d  = st_ptr_i;
      len_d  = st_len_i;
    end
    if (save_we_i)      save_d      = save_wdata_i;
    if (save_wide_we_i) save_wide_d = save_wide_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= M_IDLE;
      ptr_q       <= '0;
      len_q       <= '0;
      cnt_q       <= '0;
      save_q      <= '0;
      save_wide_q <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      ptr_q       <= ptr_d;
      len_q       <= len_d;
      cnt_q       <= cnt_d;
      save_q      <= save_d;
      save_wide_q <= save_wide_d;
    end
  end

  assign buf_idx_o    = adv_idx;
  assign fill_idx_o   = ptr_q;
  assign fetch_free_o = !suspend_i && ((mode_q == M_REPLAY) || (mode_q == M_EXIT));
  assign mode_o       = mode_q;
  assign ptr_o        = ptr_q;
  assign len_o        = len_q;
  assign cnt_o        = cnt_q;
  assign save_o       = save_q;
  assign save_wide_o  = save_wide_q;
endmodule

// File: rtl/loop_cache.sv
module loop_cache
  import lc_pkg::*;
#(
  parameter int unsigned DEPTH  = 31,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned CNT_W  = 16,
  localparam int unsigned PTR_W  = $clog2(DEPTH + 1),
  localparam int unsigned LEN_W  = PTR_W + 1,
  localparam int unsigned ADDR_W = PTR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_valid_i,
  input  logic [WORD_W-1:0] fetch_word_i,
  input  logic              fetch_wide_i,
  input  logic              loop_start_i,
  input  logic [CNT_W-1:0]  loop_cnt_i,
  input  logic [LEN_W-1:0]  loop_len_i,
  input  logic              suspend_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic              issue_valid_o,
  output logic [WORD_W-1:0] issue_word_o,
  output logic              issue_wide_o,
  output logic              fetch_free_o,
  output logic              loop_active_o
);
  localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(2 ** PTR_W);
  localparam logic [ADDR_W-1:0] A_STATE = A_CNT + 1'b1;
  localparam logic [ADDR_W-1:0] A_SAVE  = A_CNT + 2'd2;
  localparam logic [ADDR_W-1:0] A_MASK  = A_CNT + 2'd3;

  lc_mode_e          mode_w;
  logic [PTR_W-1:0]  ptr_w, len_w, buf_idx_w, fill_idx_w;
  logic [CNT_W-1:0]  cnt_w;
  logic [WORD_W-1:0] save_w, buf_word_w, port_word_w;
  logic [DEPTH-1:0]  mask_w;
  logic              save_wide_w, buf_wide_w, fill_we_w, buf_sel;
  logic              port_we_w, mask_we_w, cnt_we_w, state_we_w, save_we_w;

  assign buf_sel    = reg_addr_i < ADDR_W'(DEPTH);
  assign port_we_w  = reg_we_i && buf_sel;
  assign cnt_we_w   = reg_we_i && (reg_addr_i == A_CNT);
  assign state_we_w = reg_we_i && (reg_addr_i == A_STATE);
  assign save_we_w  = reg_we_i && (reg_addr_i == A_SAVE);
  assign mask_we_w  = reg_we_i && (reg_addr_i == A_MASK);

  lc_store #(.DEPTH(DEPTH), .WORD_W(WORD_W), .PTR_W(PTR_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fill_we_i   (fill_we_w),
    .fill_idx_i  (fill_idx_w),
    .fill_word_i (fetch_word_i),
    .fill_wide_i (fetch_wide_i),
    .port_we_i   (port_we_w),
    .port_idx_i  (reg_addr_i[PTR_W-1:0]),
    .port_word_i (reg_wdata_i),
    .mask_we_i   (mask_we_w),
    .mask_i      (reg_wdata_i[DEPTH-1:0]),
    .rd_idx_i    (buf_idx_w),
    .rd_word_o   (buf_word_w),
    .rd_wide_o   (buf_wide_w),
    .port_word_o (port_word_w),
    .mask_o      (mask_w)
  );

  lc_seq #(
    .DEPTH(DEPTH), .WORD_W(WORD_W), .CNT_W(CNT_W), .PTR_W(PTR_W), .LEN_W(LEN_W)
  ) u_seq (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .suspend_i         (suspend_i),
    .loop_start_i      (loop_start_i),
    .loop_cnt_i        (loop_cnt_i),
    .loop_len_i        (loop_len_i),
    .fetch_valid_i     (fetch_valid_i),
    .fetch_word_i      (fetch_word_i),
    .fetch_wide_i      (fetch_wide_i),
    .buf_word_i        (buf_word_w),
    .buf_wide_i        (buf_wide_w),
    .buf_idx_o         (buf_idx_w),
    .fill_we_o         (fill_we_w),
    .fill_idx_o        (fill_idx_w),
    .cnt_we_i          (cnt_we_w),
    .cnt_wdata_i       (reg_wdata_i[CNT_W-1:0]),
    .state_we_i        (state_we_w),
    .st_mode_i         (reg_wdata_i[1:0]),
    .st_ptr_i          (reg_wdata_i[PTR_W+1:2]),
    .st_len_i          (reg_wdata_i[2*PTR_W+1:PTR_W+2]),
    .save_we_i         (save_we_w),
    .save_wdata_i      (reg_wdata_i),
    .save_wide_we_i    (mask_we_w),
    .save_wide_wdata_i (reg_wdata_i[WORD_W-1]),
    .issue_valid_o     (issue_valid_o),
    .issue_word_o      (issue_word_o),
    .issue_wide_o      (issue_wide_o),
    .fetch_free_o      (fetch_free_o),
    .mode_o            (mode_w),
    .ptr_o             (ptr_w),
    .len_o             (len_w),
    .cnt_o             (cnt_w),
    .save_o            (save_w),
    .save_wide_o       (save_wide_w)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (buf_sel) begin
      reg_rdata_o = port_word_w;
    end else begin
      case (reg_addr_i)
        A_CNT:   reg_rdata_o = WORD_W'(cnt_w);
        A_STATE: reg_rdata_o = WORD_W'({len_w, ptr_w, mode_w});
        A_SAVE:  reg_rdata_o = save_w;
        A_MASK: begin
          reg_rdata_o             = WORD_W'(mask_w);
          reg_rdata_o[WORD_W-1]   = save_wide_w;
        end
        default: reg_rdata_o = '0;
      endcase
    end
  end

  assign loop_active_o = (mode_w != M_IDLE);
endmodule

// File: rtl/loop_cache_chk.sv
module loop_cache_chk
  import lc_pkg::*;
#(
  parameter int unsigned DEPTH = 31,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned LEN_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             suspend_i,
  input logic             reg_we_i,
  input logic             loop_start_i,
  input logic [CNT_W-1:0] loop_cnt_i,
  input logic [LEN_W-1:0] loop_len_i,
  input logic             fetch_valid_i,
  input logic             issue_valid_o,
  input logic             fetch_free_o,
  input logic             loop_active_o,
  input logic [1:0]       mode_i,
  input logic [CNT_W-1:0] cnt_i
);
  p_passthru_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!loop_active_o && !suspend_i) |-> (issue_valid_o == fetch_valid_i) && !fetch_free_o);

  p_bad_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop_start_i && !loop_active_o && !suspend_i && !reg_we_i &&
     ((loop_cnt_i == '0) || (loop_len_i == '0) || (loop_len_i > LEN_W'(DEPTH))))
    |=> !loop_active_o);

  p_free_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_free_o |-> issue_valid_o);

  p_exit_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == M_EXIT && !suspend_i && !reg_we_i) |=> (mode_i == M_IDLE));

  p_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_i |-> (!issue_valid_o && !fetch_free_o));

  p_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (suspend_i && !reg_we_i) |=> ($stable(mode_i) && $stable(cnt_i)));
endmodule

bind loop_cache loop_cache_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .suspend_i     (suspend_i),
  .reg_we_i      (reg_we_i),
  .loop_start_i  (loop_start_i),
  .loop_cnt_i    (loop_cnt_i),
  .loop_len_i    (loop_len_i),
  .fetch_valid_i (fetch_valid_i),
  .issue_valid_o (issue_valid_o),
  .fetch_free_o  (fetch_free_o),
  .loop_active_o (loop_active_o),
  .mode_i        (mode_w),
  .cnt_i         (cnt_w)
);

// File: tb/loop_cache_tb.sv
module loop_cache_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fetch_valid_i = 1'b0;
  logic [31:0] fetch_word_i = '0;
  logic        fetch_wide_i = 1'b0;
  logic        loop_start_i = 1'b0;
  logic [15:0] loop_cnt_i = '0;
  logic [5:0]  loop_len_i = '0;
  logic        suspend_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [5:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        issue_valid_o;
  logic [31:0] issue_word_o;
  logic        issue_wide_o;
  logic        fetch_free_o;
  logic        loop_active_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  loop_cache u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .fetch_valid_i(fetch_valid_i), .fetch_word_i(fetch_word_i), .fetch_wide_i(fetch_wide_i),
    .loop_start_i(loop_start_i), .loop_cnt_i(loop_cnt_i), .loop_len_i(loop_len_i),
    .suspend_i(suspend_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .issue_valid_o(issue_valid_o), .issue_word_o(issue_word_o), .issue_wide_o(issue_wide_o),
    .fetch_free_o(fetch_free_o), .loop_active_o(loop_active_o)
  );

  localparam logic [5:0] A_CNT = 6'd32, A_STATE = 6'd33, A_SAVE = 6'd34, A_MASK = 6'd35;

  // {start, cnt, len, fvalid, word, wide | exp_valid, exp_word, exp_wide, exp_free}
  localparam int NV = 14;
  localparam logic [91:0] VEC [NV] = '{
    {1'b0, 16'd0, 6'd0, 1'b1, 32'h0000_1000, 1'b0, 1'b1, 32'h0000_1000, 1'b0, 1'b0},
    {1'b0, 16'd0, 6'd0, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b0},
    {1'b1, 16'd3, 6'd3, 1'b1, 32'h0000_2000, 1'b0, 1'b1, 32'h0000_2000, 1'b0, 1'b0},
    {1'b0, 16'd0, 6'd0, 1'b1, 32'h0000_00B0, 1'b0, 1'b1, 32'h0000_00B0, 1'b0, 1'b0},
    {1'b0, 16'd0, 6'd0, 1'b1, 32'h0000_00B1, 1'b1, 1'b1, 32'h0000_00B1, 1'b1, 1'b0},
    {1'b0, 16'd0, 6'd0, 1'b1, 32'h0000_00B2, 1'b0, 1'b1, 32'h0000_00B2, 1'b0, 1'b0},
    {1'b0, 16'd0, 6'd0, 1'b1, 32'h0000_00F0, 1'b1, 1'b1, 32'h0000_00B0, 1'b0, 1'b0},
    {1'b0, 16'd0, 6'd0, 1'b1, 32'h0000_DEAD, 1'b0, 1'b1, 32'h0000_00B1, 1'b1, 1'b1},
    {1'b1, 16'd1, 6'd1, 1'b0, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_00B2, 1'b0, 1'b1},
    {1'b0, 16'd0, 6'd0, 1'b0, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_00B0, 1'b0, 1'b1},
    {1'b0, 16'd0, 6'd0, 1'b0, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_00B1, 1'b1, 1'b1},
    {1'b0, 16'd0, 6'd0, 1'b0, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_00B2, 1'b0, 1'b1},
    {1'b0, 16'd0, 6'd0, 1'b0, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_00F0, 1'b1, 1'b1},
    {1'b0, 16'd0, 6'd0, 1'b1, 32'h0000_3000, 1'b1, 1'b1, 32'h0000_3000, 1'b1, 1'b0}
  };
  localparam logic [23:0] TAGS [NV] = '{
    "R1 ", "R1 ", "R3 ", "R3 ", "R7 ", "R3 ", "R4 ",
    "R11", "R11", "R4 ", "R7 ", "R4 ", "R5 ", "R1 "
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic st, input logic [15:0] c, input logic [5:0] l,
                       input logic fv, input logic [31:0] w, input logic wi);
    loop_start_i  = st;
    loop_cnt_i    = c;
    loop_len_i    = l;
    fetch_valid_i = fv;
    fetch_word_i  = w;
    fetch_wide_i  = wi;
  endtask

  function automatic logic [63:0] issued();
    return {29'd0, issue_valid_o, issue_word_o, issue_wide_o, fetch_free_o};
  endfunction

  function automatic logic [63:0] expv(input logic v, input logic [31:0] w,
                                       input logic wi, input logic f);
    return {29'd0, v, w, wi, f};
  endfunction

  task automatic reg_rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
    @(negedge clk);
  endtask

  task automatic reg_wr(input logic [5:0] a, input logic [31:0] d);
    reg_we_i = 1'b1;
    reg_addr_i = a;
    reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic        st, fv, wi, ev, ew_i, ef;
    logic [15:0] c;
    logic [5:0]  l;
    logic [31:0] w, ew, d;
    int          n_e0, gaps, low_free, guard;
    logic        seen_end;

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // reset state
    chk("reset", {62'd0, loop_active_o, fetch_free_o}, 64'd0);
    @(negedge clk);
    reg_rd(A_CNT, d);   chk("reset R9", {32'd0, d}, 64'd0);
    reg_rd(A_STATE, d); chk("reset R9", {32'd0, d}, 64'd0);

    // vector table: fill, replay, exit with mixed widths
    for (int i = 0; i < NV; i++) begin
      {st, c, l, fv, w, wi, ev, ew, ew_i, ef} = VEC[i];
      drive(st, c, l, fv, w, wi);
      #1;
      chk(TAGS[i], ev ? issued() : {issued() & 64'h8_0000_0001},
          expv(ev, ew, ew_i, ef) & (ev ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h8_0000_0001));
      @(negedge clk);
    end
    drive(0, 0, 0, 0, 0, 0);
    @(negedge clk);

    // R2: malformed loop starts
    for (int k = 0; k < 3; k++) begin
      drive(1'b1, (k == 0) ? 16'd0 : 16'd4, (k == 1) ? 6'd0 : ((k == 2) ? 6'd32 : 6'd3),
            1'b1, 32'h0000_0A00, 1'b0);
      @(negedge clk);
      drive(1'b0, 0, 0, 1'b1, 32'h0000_0A01 + k, 1'b1);
      #1;
      chk("R2", {30'd0, loop_active_o, issued()[33:0]},
          {30'd0, 1'b0, expv(1'b1, 32'h0000_0A01 + k, 1'b1, 1'b0)[33:0]});
      @(negedge clk);
    end

    // R6: single pass, follow-on issued directly
    drive(1, 16'd1, 6'd2, 0, 0, 0); @(negedge clk);
    drive(0, 0, 0, 1, 32'h0000_00C0, 0); #1 chk("R3", issued(), expv(1, 32'hC0, 0, 0)); @(negedge clk);
    drive(0, 0, 0, 1, 32'h0000_00C1, 0); @(negedge clk);
    drive(0, 0, 0, 1, 32'h0000_00C2, 1); #1 chk("R6", issued(), expv(1, 32'hC2, 1, 0)); @(negedge clk);
    drive(0, 0, 0, 0, 0, 0); #1 chk("R6", {63'd0, loop_active_o}, 64'd0); @(negedge clk);

    // R8/R9/R10: suspend between passes, clobber, restore, resume
    drive(1, 16'd4, 6'd2, 0, 0, 0); @(negedge clk);
    drive(0, 0, 0, 1, 32'h0000_00D0, 0); @(negedge clk);
    drive(0, 0, 0, 1, 32'h0000_00D1, 1); @(negedge clk);
    drive(0, 0, 0, 1, 32'h0000_00D2, 1); #1 chk("R4", issued(), expv(1, 32'hD0, 0, 0)); @(negedge clk);
    drive(0, 0, 0, 0, 0, 0); #1 chk("R4", issued(), expv(1, 32'hD1, 1, 1)); @(negedge clk);
    suspend_i = 1'b1;
    #1 chk("R8", {62'd0, issue_valid_o, fetch_free_o}, 64'd0);
    @(negedge clk);
    reg_rd(A_CNT, d);   chk("R9 cnt", {32'd0, d}, 64'd2);
    reg_rd(A_STATE, d); chk("R9 state", {32'd0, d}, 64'h102);
    reg_rd(A_SAVE, d);  chk("R9 save", {32'd0, d}, 64'hD2);
    reg_rd(A_MASK, d);  chk("R9 mask", {32'd0, d}, 64'h8000_0002);
    reg_rd(6'd0, d);    chk("R9 entry", {32'd0, d}, 64'hD0);
    reg_rd(6'd1, d);    chk("R9 entry", {32'd0, d}, 64'hD1);
    chk("R8 frozen", {63'd0, loop_active_o}, 64'd1);
    reg_wr(A_STATE, 32'd0);
    reg_wr(A_CNT, 32'd0);
    reg_wr(6'd0, 32'h0000_00EE);
    reg_wr(A_MASK, 32'd0);
    #1 chk("R9 write", {63'd0, loop_active_o}, 64'd0);
    reg_rd(6'd0, d);    chk("R9 write", {32'd0, d}, 64'hEE);
    reg_wr(6'd0, 32'h0000_00D0);
    reg_wr(A_MASK, 32'h8000_0002);
    reg_wr(A_CNT, 32'd2);
    reg_wr(A_SAVE, 32'h0000_00D2);
    reg_wr(A_STATE, 32'h0000_0102);
    suspend_i = 1'b0;
    drive(1, 16'd2, 6'd1, 1, 32'h0000_5555, 0);
    #1 chk("R10", issued(), expv(1, 32'hD0, 0, 1)); @(negedge clk);
    #1 chk("R10", issued(), expv(1, 32'hD1, 1, 1)); @(negedge clk);
    #1 chk("R10", issued(), expv(1, 32'hD0, 0, 1)); @(negedge clk);
    #1 chk("R10", issued(), expv(1, 32'hD1, 1, 1)); @(negedge clk);
    #1 chk("R5", issued(), expv(1, 32'hD2, 1, 1)); @(negedge clk);
    drive(0, 0, 0, 1, 32'h0000_5555, 0);
    #1 chk("R1", issued(), expv(1, 32'h5555, 0, 0)); @(negedge clk);

    // R4: maximum count, one-word body
    drive(1, 16'hFFFF, 6'd1, 0, 0, 0); @(negedge clk);
    n_e0 = 0; gaps = 0; low_free = 0; seen_end = 1'b0; guard = 0;
    drive(0, 0, 0, 1, 32'h0000_00E0, 0);
    #1 if (issue_valid_o && issue_word_o == 32'hE0) begin n_e0++; if (!fetch_free_o) low_free++; end
    @(negedge clk);
    drive(0, 0, 0, 1, 32'h0000_00E1, 1);
    while (!seen_end && guard < 70000) begin
      #1;
      if (!issue_valid_o) gaps++;
      else if (issue_word_o == 32'hE0) begin n_e0++; if (!fetch_free_o) low_free++; end
      else if (issue_word_o == 32'hE1) seen_end = 1'b1;
      @(negedge clk);
      drive(1, 16'd5, 6'd2, 1, 32'h0000_7777, 0);
      guard++;
    end
    chk("R4 count", 64'(n_e0), 64'd65535);
    chk("R4 gaps", 64'(gaps), 64'd0);
    chk("R4 free", 64'(low_free), 64'd2);
    drive(0, 0, 0, 1, 32'h0000_7777, 0);
    #1 chk("R5", issued(), expv(1, 32'h7777, 0, 0)); @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule